// File: doc/BRIEF.md
# Memory Pattern Write-Readback Checker

This block runs a fixed memory stress test each time it is started. It first writes 64 32-bit test words to consecutive word addresses, beginning at a base address set by a parameter. Only after the last write has been accepted does it read every word back. Each word is read a number of times set by a parameter, and every read is compared with the word that was written there.

Once the last read has returned, the block samples an error-status vector from the memory controller. It then signals completion with a one-cycle `done` pulse. In that same cycle `pass` reports whether every read matched and the status vector was zero.

The test words come from a small piece of logic that decodes the word index. It is arranged in groups of eight that swap polarity from one group to the next, so that data lines toggle hard across bursts. A mismatch does not cut the test short, so every run takes the same number of memory transactions.

Top module: `mem_pattern_checker`

## Requirements
- R1: While reset is held, and in the first cycle after it, `done`, `pass` and `mem_req` are all 0.
- R2: The word written at index i (0..63) depends on a value pair chosen by i/16: 0 selects 0x00000000/0xFFFFFFFF, 1 selects 0xAAAAAAAA/0x55555555, 2 selects 0xA5A5A5A5/0x5A5A5A5A and 3 selects 0xAA55AA55/0x55AA55AA. The first value of the pair is used when (i mod 4) < 2, and the second value otherwise. When i/8 is odd, the choice is swapped.
- R3: The word for index i is written to address BASE_ADDR + 4*i. Writes are issued in increasing index order, and each index is written exactly once per run.
- R4: All 64 writes are accepted before the first read request is issued.
- R5: Each index is read exactly NUM_READS times, back to back, before the next index is read. Indices are read in increasing order, with the same address mapping as in R3.
- R6: A read whose data differs from the word written at that index makes `pass` 0 at the end of the run. The run still performs all 64*NUM_READS reads.
- R7: `err_status` is sampled once, after the last read has returned. Any nonzero bit at that point makes `pass` 0. Values that are nonzero only earlier in the run have no effect.
- R8: `done` is high for exactly one cycle per run. `pass` is high only in that cycle, and only when the run had no mismatch and no status error.
- R9: A request (`mem_req` high) holds its address, write enable and write data unchanged until a cycle in which `mem_ready` is high.
- R10: `start` is ignored while a run is in progress. It neither restarts the sequence nor adds transactions or `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when the block is idle |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Result, valid only while done is high |
| mem_req | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with mem_rvalid |
| mem_rvalid | input | 1 | Read data returned |
| err_status | input | ERR_W | Error-status bits from the memory controller |

## Verification
The assertions take the memory side as given, and three input conditions follow from that:
- `mem_rvalid` arrives only while a read is outstanding, at least one cycle after the read was accepted.
- At most one read is outstanding at any time.
- `start` does not need to be qualified by the block's state.

The bench's behavioural memory keeps within these conditions. It returns each accepted read as a single-cycle `mem_rvalid` after a random delay of one to three cycles. It drives `mem_ready` at random, whether or not a request is pending. It raises `start` pulses during a run as well as while the block is idle.

Faults are injected in three ways: a corrupted stored word, a corrupted single read, and status bits that are raised either early or late in the run.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WRITE,
      ST_RD_REQ,
      ST_RD_WAIT,
      ST_STATUS,
      ST_DONE
   } mpc_state_e;

   // Test word for a 6-bit index: bits [5:4] pick the value pair,
   // bit 1 picks the second value, bit 3 (odd group) swaps the choice.
   function automatic logic [31:0] mpc_pattern(input logic [5:0] idx);
      logic [31:0] first;
      case (idx[5:4])
         2'd0:    first = 32'h0000_0000;
         2'd1:    first = 32'hAAAA_AAAA;
         2'd2:    first = 32'hA5A5_A5A5;
         default: first = 32'hAA55_AA55;
      endcase
      return first ^ {32{idx[1] ^ idx[3]}};
   endfunction

endpackage

// File: rtl/mpc_pattern_gen.sv
module mpc_pattern_gen #(
   parameter int IDX_W  = 6,
   parameter int DATA_W = 32
) (
   input  logic [IDX_W-1:0]  idx,
   output logic [DATA_W-1:0] word
);
   import mpc_pkg::*;

   initial begin : p_param_chk
      assert (IDX_W == 6 && DATA_W == 32)
         else $error("mpc_pattern_gen: pattern is defined for 64 words of 32 bits");
   end

   assign word = mpc_pattern(idx);

endmodule

// File: rtl/mpc_sequencer.sv
module mpc_sequencer #(
   parameter int NUM_WORDS = 64,
   parameter int NUM_READS = 2,
   parameter int IDX_W     = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             mem_ready,
   input  logic             mem_rvalid,
   output logic [IDX_W-1:0] idx_o,
   output logic             req_o,
   output logic             we_o,
   output logic             clr_o,
   output logic             cmp_en_o,
   output logic             stat_en_o,
   output logic             done_o
);
   import mpc_pkg::*;

   localparam int RCNT_W = (NUM_READS > 1) ? $clog2(NUM_READS) : 1;

   mpc_state_e       state;
   logic [IDX_W-1:0] idx;
   logic             idx_last;
   logic             rd_last;
   logic             rd_step;

   assign idx_last  = (idx == IDX_W'(NUM_WORDS - 1));
   assign rd_step   = (state == ST_RD_WAIT) && mem_rvalid;
   assign clr_o     = (state == ST_IDLE) && start;
   assign req_o     = (state == ST_WRITE) || (state == ST_RD_REQ);
   assign we_o      = (state == ST_WRITE);
   assign cmp_en_o  = rd_step;
   assign stat_en_o = (state == ST_STATUS);
   assign done_o    = (state == ST_DONE);
   assign idx_o     = idx;

   generate
      if (NUM_READS > 1) begin : g_multi_read
         logic [RCNT_W-1:0] rcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       rcnt <= '0;
            else if (clr_o)   rcnt <= '0;
            else if (rd_step) rcnt <= rd_last ? '0 : rcnt + 1'b1;
         end
         assign rd_last = (rcnt == RCNT_W'(NUM_READS - 1));
      end else begin : g_single_read
         assign rd_last = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         idx   <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               state <= ST_WRITE;
               idx   <= '0;
            end
            ST_WRITE: if (mem_ready) begin
               if (idx_last) begin
                  idx   <= '0;
                  state <= ST_RD_REQ;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            ST_RD_REQ: if (mem_ready) state <= ST_RD_WAIT;
            ST_RD_WAIT: if (mem_rvalid) begin
               if (!rd_last) begin
                  state <= ST_RD_REQ;
               end else if (idx_last) begin
                  state <= ST_STATUS;
               end else begin
                  idx   <= idx + 1'b1;
                  state <= ST_RD_REQ;
               end
            end
            ST_STATUS: state <= ST_DONE;
            ST_DONE:   state <= ST_IDLE;
            default:   state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/mpc_compare.sv
module mpc_compare #(
   parameter int DATA_W = 32,
   parameter int ERR_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              cmp_en,
   input  logic [DATA_W-1:0] rdata,
   input  logic [DATA_W-1:0] expect_word,
   input  logic              stat_en,
   input  logic [ERR_W-1:0]  status,
   output logic              fail_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             fail_o <= 1'b0;
      else if (clr)                           fail_o <= 1'b0;
      else if (cmp_en && rdata != expect_word) fail_o <= 1'b1;
      else if (stat_en && |status)            fail_o <= 1'b1;
   end
endmodule

// File: rtl/mem_pattern_checker.sv
module mem_pattern_checker #(
   parameter int              ADDR_W    = 32,
   parameter int              DATA_W    = 32,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0000_1000,
   parameter int              NUM_WORDS = 64,
   parameter int              NUM_READS = 2,
   parameter int              ERR_W     = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              done,
   output logic              pass,
   output logic              mem_req,
   input  logic              mem_ready,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_rvalid,
   input  logic [ERR_W-1:0]  err_status
);
   localparam int IDX_W = $clog2(NUM_WORDS);

   initial begin : p_param_chk
      assert (NUM_WORDS == 64) else $error("NUM_WORDS must be 64");
      assert (DATA_W == 32)    else $error("DATA_W must be 32");
      assert (NUM_READS >= 1)  else $error("NUM_READS must be at least 1");
      assert (ERR_W >= 1)      else $error("ERR_W must be at least 1");
      assert (ADDR_W > IDX_W + 2) else $error("ADDR_W too small");
      assert (BASE_ADDR[1:0] == 2'b00) else $error("BASE_ADDR must be word aligned");
   end

   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] word;
   logic              clr, cmp_en, stat_en, fail;

   mpc_sequencer #(
      .NUM_WORDS(NUM_WORDS),
      .NUM_READS(NUM_READS),
      .IDX_W    (IDX_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .mem_ready (mem_ready),
      .mem_rvalid(mem_rvalid),
      .idx_o     (idx),
      .req_o     (mem_req),
      .we_o      (mem_we),
      .clr_o     (clr),
      .cmp_en_o  (cmp_en),
      .stat_en_o (stat_en),
      .done_o    (done)
   );

   mpc_pattern_gen #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_pat (
      .idx (idx),
      .word(word)
   );

   mpc_compare #(.DATA_W(DATA_W), .ERR_W(ERR_W)) u_cmp (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .cmp_en     (cmp_en),
      .rdata      (mem_rdata),
      .expect_word(word),
      .stat_en    (stat_en),
      .status     (err_status),
      .fail_o     (fail)
   );

   assign mem_addr  = BASE_ADDR + ADDR_W'({idx, 2'b00});
   assign mem_wdata = word;
   assign pass      = done && !fail;

endmodule

// File: rtl/mpc_checker.sv
module mpc_checker #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              done,
   input logic              pass,
   input logic              mem_req,
   input logic              mem_ready,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata
);
   logic rd_phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   rd_phase <= 1'b0;
      else if (done)                rd_phase <= 1'b0;
      else if (mem_req && !mem_we)  rd_phase <= 1'b1;
   end

   a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata));

   a_r8_pass_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
      pass |-> done);

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r4_no_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> !rd_phase);

   a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_addr[1:0] == 2'b00);

   a_r8_quiet_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req);

endmodule

bind mem_pattern_checker mpc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .done     (done),
   .pass     (pass),
   .mem_req  (mem_req),
   .mem_ready(mem_ready),
   .mem_we   (mem_we),
   .mem_addr (mem_addr),
   .mem_wdata(mem_wdata)
);

// File: tb/mem_pattern_checker_test.sv
module mem_pattern_checker_test;
   localparam int          CLK_PERIOD = 10;
   localparam logic [31:0] BASE       = 32'h0000_2000;
   localparam int          NREADS     = 3;
   localparam int          ERR_W      = 4;
   localparam int          NW         = 64;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              done, pass, mem_req, mem_we;
   logic              mem_ready = 1'b0;
   logic              mem_rvalid = 1'b0;
   logic [31:0]       mem_addr, mem_wdata;
   logic [31:0]       mem_rdata = '0;
   logic [ERR_W-1:0]  err_status = '0;

   int checks = 0;
   int errors = 0;

   // memory model and run bookkeeping
   logic [31:0] mem [NW];
   int          wr_cnt, rd_cnt, wr_bad, rd_bad, order_bad, done_cnt, lat_cnt;
   logic [31:0] pend_data;
   int          f_idx, f_k;
   bit          f_store;
   logic [31:0] f_mask;
   logic [ERR_W-1:0] e_early, e_late;

   mem_pattern_checker #(
      .ADDR_W(32), .DATA_W(32), .BASE_ADDR(BASE),
      .NUM_WORDS(NW), .NUM_READS(NREADS), .ERR_W(ERR_W)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .done(done), .pass(pass),
      .mem_req(mem_req), .mem_ready(mem_ready), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_rvalid(mem_rvalid), .err_status(err_status)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] exp_word(input int i);
      logic [31:0] a;
      bit second;
      case (i / 16)
         0: a = 32'h0000_0000;
         1: a = 32'hAAAA_AAAA;
         2: a = 32'hA5A5_A5A5;
         default: a = 32'hAA55_AA55;
      endcase
      second = ((i % 4) >= 2);
      if (((i / 8) % 2) == 1) second = !second;
      return second ? ~a : a;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // behavioural memory, all activity away from the active edge
   always @(negedge clk) begin
      int widx, k;
      mem_rvalid = 1'b0;
      if (!rst_n) begin
         mem_ready = 1'b0;
         lat_cnt   = 0;
      end else begin
         if (lat_cnt > 0) begin
            lat_cnt--;
            if (lat_cnt == 0) begin
               mem_rvalid = 1'b1;
               mem_rdata  = pend_data;
            end
         end
         mem_ready = ($urandom_range(0, 3) != 0);
         err_status = (rd_cnt > 0) ? e_late : e_early;
         if (done) done_cnt++;
         if (mem_req && mem_ready) begin
            widx = int'((mem_addr - BASE) >> 2);
            if (mem_addr < BASE || widx >= NW) begin
               if (mem_we) wr_bad++; else rd_bad++;
            end else if (mem_we) begin
               if (widx != wr_cnt || mem_wdata != exp_word(wr_cnt)) wr_bad++;
               if (rd_cnt != 0) order_bad++;
               mem[widx] = (f_store && widx == f_idx) ? (mem_wdata ^ f_mask) : mem_wdata;
               wr_cnt++;
            end else begin
               if (widx != rd_cnt / NREADS) rd_bad++;
               if (wr_cnt != NW) order_bad++;
               k = rd_cnt % NREADS;
               pend_data = mem[widx];
               if (!f_store && widx == f_idx && k == f_k) pend_data ^= f_mask;
               lat_cnt = $urandom_range(1, 3);
               rd_cnt++;
            end
         end
      end
   end

   task automatic run(input string name, input int fidx, input int fk, input bit fstore,
                      input logic [ERR_W-1:0] eearly, input logic [ERR_W-1:0] elate,
                      input bit extra_start);
      bit exp_pass;
      bit seen;
      int cyc;
      f_idx = fidx; f_k = fk; f_store = fstore;
      f_mask = 32'h1 << $urandom_range(0, 31);
      e_early = eearly; e_late = elate;
      wr_cnt = 0; rd_cnt = 0; wr_bad = 0; rd_bad = 0; order_bad = 0; done_cnt = 0;
      for (int i = 0; i < NW; i++) mem[i] = 32'hDEAD_0000 + i;
      exp_pass = (fidx < 0) && (elate == '0);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      seen = 1'b0;
      cyc = 0;
      while (!seen && cyc < 5000) begin
         @(negedge clk);
         cyc++;
         if (extra_start && (cyc == 20 || cyc == 300)) start = 1'b1;
         else start = 1'b0;
         if (done) begin
            seen = 1'b1;
            chk(pass == exp_pass, "R8", {name, " pass at done"}, pass, exp_pass);
         end else begin
            if (pass) chk(1'b0, "R8", {name, " pass without done"}, 1, 0);
         end
      end
      start = 1'b0;
      chk(seen, "R8", {name, " done reached"}, seen, 1);
      chk(wr_cnt == NW && wr_bad == 0, "R2", {name, " write data/order"}, wr_bad, 0);
      chk(rd_cnt == NW * NREADS, "R6", {name, " total reads"}, rd_cnt, NW * NREADS);
      chk(rd_bad == 0, "R5", {name, " read order"}, rd_bad, 0);
      chk(order_bad == 0, "R4", {name, " writes before reads"}, order_bad, 0);
      repeat (30) @(negedge clk);
      chk(done_cnt == 1, "R10", {name, " done pulses"}, done_cnt, 1);
      chk(!mem_req, "R10", {name, " idle after run"}, mem_req, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      f_idx = -1; f_k = 0; f_store = 0; f_mask = 1; e_early = '0; e_late = '0;
      wr_cnt = 0; rd_cnt = 0; done_cnt = 0; lat_cnt = 0;
      repeat (3) @(negedge clk);
      chk(!done && !pass && !mem_req, "R1", "outputs in reset", {done, pass, mem_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done && !pass && !mem_req, "R1", "outputs after reset", {done, pass, mem_req}, 0);

      run("clean", -1, 0, 0, '0, '0, 0);                    // R2 R3 R5 R8
      run("read_fault_mid", 37, 1, 0, '0, '0, 0);           // R6
      run("store_fault_first", 0, 0, 1, '0, '0, 0);         // R6
      run("read_fault_last", 63, NREADS - 1, 0, '0, '0, 0); // R6 boundary
      run("status_late", -1, 0, 0, '0, 4'b0100, 0);         // R7
      run("status_early_only", -1, 0, 0, 4'b1111, '0, 0);   // R7 ignored early
      run("start_mid_run", -1, 0, 0, '0, '0, 1);            // R10
      run("start_mid_fault", 12, 2, 0, '0, '0, 1);          // R10 R6

      for (int r = 0; r < 6; r++) begin
         int fi, fk;
         bit fs;
         logic [ERR_W-1:0] el;
         fi = ($urandom_range(0, 2) == 0) ? -1 : int'($urandom_range(0, NW - 1));
         fk = $urandom_range(0, NREADS - 1);
         fs = $urandom_range(0, 1);
         el = ($urandom_range(0, 3) == 0) ? ERR_W'($urandom_range(1, 15)) : '0;
         run("random", fi, fk, fs, ERR_W'($urandom_range(0, 15)), el, $urandom_range(0, 1));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule